// File: doc/BRIEF.md
# Shared-Timebase Capture/Compare Array

The block holds one 16-bit up-counter that serves as a common time reference for several capture/compare units, five by default. The counter advances on a tick taken from one of four places: the clock divided by a first prescale ratio, the clock divided by a second ratio, a one-cycle pulse from a neighbouring timer, or rising edges on an external count pin. A run bit starts and stops the counter. An optional idle gate holds it while the chip-level idle input is high. When the counter wraps from all ones to zero, it sets an overflow flag.

Each unit owns one pin and has its own mode byte and 16-bit capture/compare word. In capture mode a selected edge on the unit's pin copies the counter into that word. In compare mode the unit raises its flag when the counter reaches the word. It can also invert its output pin on every such match, which gives a high-speed toggle output. Flags are set by hardware and cleared by software writes to the control byte. A single interrupt line is high whenever any flag is set together with its enable.

Top module: `ccu_array`

## Requirements
- R1: The configuration byte (address 1) selects the count source in bits 2:1. Code 00 ticks once every DIV_A (12) clocks, 01 once every DIV_B (4) clocks, 10 on each clock where `t0_ovf_i` is high, and 11 on synchronized rising edges of `ext_cnt_i`. Each tick adds exactly one to the counter, in the clock edge that samples the tick.
- R2: `ext_cnt_i` passes through two flip-flops before edge detection. An input level change at clock edge k advances the counter at edge k+3. Each rising edge counts once, however long the level is held.
- R3: The counter advances only while the run bit (control byte bit 6) is 1. When it is 0, the counter holds its value.
- R4: The counter wraps from 0xFFFF to 0x0000. That same edge sets the overflow flag (control bit 7). The flag raises `irq_o` only while configuration bit 0 is 1.
- R5: With configuration bit 7 set, the counter holds while `idle_i` is high. With that bit clear, `idle_i` has no effect.
- R6: Unit n has its mode byte at address 4+n. Within that byte, bit 0 is the interrupt enable, bit 1 is the PWM bit, bit 2 enables toggle, bit 3 enables match, bit 4 enables falling-edge capture, bit 5 enables rising-edge capture and bit 6 enables the comparator. Bit 7 reads 0.
- R7: The capture/compare word of unit n sits at address 9+2n (low byte) and 10+2n (high byte). Each `cc_pin_i` bit is synchronized by two flops. An enabled edge copies the counter value into the word and sets flag n three edges after the pin changes. With both edge bits set, either transition captures. A capture takes priority over a software write to the same word in the same cycle.
- R8: With the comparator and match bits both set, flag n is set in the cycle after the counter steps onto a value equal to the word. A counter that stays on that value does not set the flag again.
- R9: With toggle also set, `cc_pin_o[n]` inverts on the same edge that sets the flag for a match. It is 0 after reset.
- R10: The control byte (address 0) holds the overflow flag in bit 7, the run bit in bit 6, a bit 5 that reads 0, and unit flags in bits 4:0. A write loads these bits. A hardware set in the same cycle wins over a written 0.
- R11: `irq_o` is high exactly when the overflow flag and its enable are both set, or when any unit flag and that unit's mode bit 0 are both set.
- R12: After reset every register reads 0 and every output is 0. The counter bytes are at addresses 2 (low) and 3 (high) and can be written. A write to the counter suppresses the increment in that cycle. Unmapped addresses read 0.
- R13: The PWM mode bit is stored and read back but has no effect on pins, flags or captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Chip idle indication |
| t0_ovf_i | input | 1 | One-cycle overflow pulse from a neighbouring timer |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| cc_pin_i | input | NMOD | Capture inputs, one per unit (asynchronous) |
| cc_pin_o | output | NMOD | Toggle outputs, one per unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The critical collision is a software write to the control byte landing in the same cycle as a hardware flag set from a capture or a match. The bench provokes it by raising a capture pin and then issuing a control write that clears the flags. It sweeps the delay between the two over several offsets, so that one offset hits the exact edge where the capture fires. A behavioural model runs alongside the design and decides the outcome each cycle: the set must survive the write. It compares the pins, the interrupt and the read data on every clock, so a lost set or a spurious one shows up as a mismatch on the cycle it happens.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;

  localparam int MB_IE   = 0;
  localparam int MB_PWM  = 1;
  localparam int MB_TOG  = 2;
  localparam int MB_MAT  = 3;
  localparam int MB_CAPN = 4;
  localparam int MB_CAPP = 5;
  localparam int MB_ECOM = 6;
  localparam int MODE_W  = 7;

  localparam int CB_OVF = 7;
  localparam int CB_RUN = 6;

  localparam int CFB_OVF_IE = 0;
  localparam int CFB_IDLE   = 7;

  localparam int A_CTRL  = 0;
  localparam int A_CFG   = 1;
  localparam int A_CNTL  = 2;
  localparam int A_CNTH  = 3;
  localparam int A_MODE0 = 4;

  typedef enum logic [1:0] {
    SRC_DIV_A = 2'b00,
    SRC_DIV_B = 2'b01,
    SRC_T0    = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] old,
                                                input logic hi,
                                                input logic [DATA_W-1:0] b);
    logic [CNT_W-1:0] r;
    r = old;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

  function automatic logic sticky_next(input logic old, input logic wr,
                                       input logic wval, input logic hw_set);
    return (wr ? wval : old) | hw_set;
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] c);
    return &c;
  endfunction
endpackage

// File: rtl/ccu_src.sv
module ccu_src #(
  parameter int DIV_A = 12,
  parameter int DIV_B = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       t0_pulse,
  input  logic       ext_rise,
  output logic       tick
);
  import ccu_pkg::*;
  localparam int PW_A = $clog2(DIV_A);
  localparam int PW_B = $clog2(DIV_B);
  localparam logic [PW_A-1:0] LAST_A = PW_A'(DIV_A - 1);
  localparam logic [PW_B-1:0] LAST_B = PW_B'(DIV_B - 1);

  logic [PW_A-1:0] pa_q;
  logic [PW_B-1:0] pb_q;
  logic tick_a, tick_b;

  assign tick_a = (pa_q == LAST_A);
  assign tick_b = (pb_q == LAST_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pb_q <= '0;
    end else begin
      pa_q <= tick_a ? '0 : pa_q + 1'b1;
      pb_q <= tick_b ? '0 : pb_q + 1'b1;
    end
  end

  always_comb begin
    unique case (src_e'(sel))
      SRC_DIV_A: tick = tick_a;
      SRC_DIV_B: tick = tick_b;
      SRC_T0:    tick = t0_pulse;
      default:   tick = ext_rise;
    endcase
  end
endmodule

// File: rtl/ccu_sync.sv
module ccu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/ccu_unit.sv
module ccu_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [7:0]  wdata,
  input  logic [15:0] cnt,
  input  logic        step,
  input  logic        rise,
  input  logic        fall,
  output logic [6:0]  mode_q,
  output logic [15:0] word_q,
  output logic        pin_q,
  output logic        hit
);
  import ccu_pkg::*;
  logic cap_ev, match_ev;

  assign cap_ev   = (mode_q[MB_CAPP] & rise) | (mode_q[MB_CAPN] & fall);
  assign match_ev = step & mode_q[MB_ECOM] & mode_q[MB_MAT] & (cnt == word_q);
  assign hit      = cap_ev | match_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      word_q <= '0;
      pin_q  <= 1'b0;
    end else begin
      if (mode_we) mode_q <= wdata[MODE_W-1:0];
      if (cap_ev)     word_q <= cnt;
      else if (lo_we) word_q <= put_byte(word_q, 1'b0, wdata);
      else if (hi_we) word_q <= put_byte(word_q, 1'b1, wdata);
      if (match_ev && mode_q[MB_TOG]) pin_q <= ~pin_q;
    end
  end
endmodule

// File: rtl/ccu_array.sv
module ccu_array #(
  parameter int NMOD  = 5,
  parameter int AW    = 5,
  parameter int DIV_A = 12,
  parameter int DIV_B = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_i,
  input  logic            t0_ovf_i,
  input  logic            ext_cnt_i,
  input  logic [NMOD-1:0] cc_pin_i,
  output logic [NMOD-1:0] cc_pin_o,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq_o
);
  import ccu_pkg::*;
  localparam int A_WORD0 = A_MODE0 + NMOD;

  logic            ovf_ie_q, idle_gate_q;
  logic [1:0]      src_q;
  logic            ovf_q, run_q;
  logic [NMOD-1:0] flag_q;
  logic [15:0]     cnt_q;
  logic            step_q;

  logic ctrl_we, cfg_we, cntl_we, cnth_we, cnt_wr;
  logic tick, ext_rise, ext_fall, cnt_inc, roll;
  logic [NMOD-1:0] pin_rise, pin_fall, hit, ie_vec;
  logic [NMOD-1:0] mode_we, lo_we, hi_we;
  logic [6:0]      mode_q [NMOD];
  logic [15:0]     word_q [NMOD];

  assign ctrl_we = reg_we && (int'(reg_addr) == A_CTRL);
  assign cfg_we  = reg_we && (int'(reg_addr) == A_CFG);
  assign cntl_we = reg_we && (int'(reg_addr) == A_CNTL);
  assign cnth_we = reg_we && (int'(reg_addr) == A_CNTH);
  assign cnt_wr  = cntl_we | cnth_we;

  ccu_sync #(.W(1)) u_ext (
    .clk(clk), .rst_n(rst_n), .raw(ext_cnt_i), .rise(ext_rise), .fall(ext_fall)
  );

  ccu_sync #(.W(NMOD)) u_pins (
    .clk(clk), .rst_n(rst_n), .raw(cc_pin_i), .rise(pin_rise), .fall(pin_fall)
  );

  ccu_src #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_src (
    .clk(clk), .rst_n(rst_n), .sel(src_q), .t0_pulse(t0_ovf_i),
    .ext_rise(ext_rise), .tick(tick)
  );

  assign cnt_inc = run_q & ~(idle_gate_q & idle_i) & tick & ~cnt_wr;
  assign roll    = cnt_inc & at_top(cnt_q);

  genvar g;
  generate
    for (g = 0; g < NMOD; g++) begin : g_unit
      assign mode_we[g] = reg_we && (int'(reg_addr) == A_MODE0 + g);
      assign lo_we[g]   = reg_we && (int'(reg_addr) == A_WORD0 + 2*g);
      assign hi_we[g]   = reg_we && (int'(reg_addr) == A_WORD0 + 2*g + 1);
      ccu_unit u_unit (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we[g]), .lo_we(lo_we[g]), .hi_we(hi_we[g]),
        .wdata(reg_wdata), .cnt(cnt_q), .step(step_q),
        .rise(pin_rise[g]), .fall(pin_fall[g]),
        .mode_q(mode_q[g]), .word_q(word_q[g]),
        .pin_q(cc_pin_o[g]), .hit(hit[g])
      );
      assign ie_vec[g] = mode_q[g][MB_IE];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_ie_q    <= 1'b0;
      idle_gate_q <= 1'b0;
      src_q       <= 2'b00;
      ovf_q       <= 1'b0;
      run_q       <= 1'b0;
      flag_q      <= '0;
      cnt_q       <= '0;
      step_q      <= 1'b0;
    end else begin
      if (cfg_we) begin
        ovf_ie_q    <= reg_wdata[CFB_OVF_IE];
        src_q       <= reg_wdata[2:1];
        idle_gate_q <= reg_wdata[CFB_IDLE];
      end
      if (ctrl_we) run_q <= reg_wdata[CB_RUN];
      ovf_q <= sticky_next(ovf_q, ctrl_we, reg_wdata[CB_OVF], roll);
      for (int i = 0; i < NMOD; i++)
        flag_q[i] <= sticky_next(flag_q[i], ctrl_we, reg_wdata[i], hit[i]);
      if (cntl_we)      cnt_q <= put_byte(cnt_q, 1'b0, reg_wdata);
      else if (cnth_we) cnt_q <= put_byte(cnt_q, 1'b1, reg_wdata);
      else if (cnt_inc) cnt_q <= cnt_q + 16'd1;
      step_q <= cnt_inc;
    end
  end

  assign irq_o = (ovf_q & ovf_ie_q) | (|(flag_q & ie_vec));

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      A_CTRL: begin
        reg_rdata[CB_OVF]     = ovf_q;
        reg_rdata[CB_RUN]     = run_q;
        reg_rdata[NMOD-1:0]   = flag_q;
      end
      A_CFG:  reg_rdata = {idle_gate_q, 4'b0000, src_q, ovf_ie_q};
      A_CNTL: reg_rdata = cnt_q[7:0];
      A_CNTH: reg_rdata = cnt_q[15:8];
      default: begin
        for (int i = 0; i < NMOD; i++) begin
          if (int'(reg_addr) == A_MODE0 + i)     reg_rdata = {1'b0, mode_q[i]};
          if (int'(reg_addr) == A_WORD0 + 2*i)   reg_rdata = word_q[i][7:0];
          if (int'(reg_addr) == A_WORD0 + 2*i+1) reg_rdata = word_q[i][15:8];
        end
      end
    endcase
  end
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk #(
  parameter int NMOD = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            idle_gate,
  input logic            idle_i,
  input logic            cnt_wr,
  input logic            cnt_inc,
  input logic [15:0]     cnt,
  input logic            ctrl_we,
  input logic            ovf,
  input logic [NMOD-1:0] flags,
  input logic            irq
);
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_gate && idle_i && !cnt_wr) |=> $stable(cnt)); // R5

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |=> (cnt == $past(cnt) + 16'd1)); // R1

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && cnt == 16'hFFFF) |=> (ovf && cnt == 16'h0000)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> ((flags & $past(flags)) == $past(flags))); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && ovf) |=> ovf); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0 && !ovf) |-> !irq); // R11
endmodule

bind ccu_array ccu_array_chk #(.NMOD(NMOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .idle_gate(idle_gate_q),
  .idle_i(idle_i), .cnt_wr(cnt_wr), .cnt_inc(cnt_inc), .cnt(cnt_q),
  .ctrl_we(ctrl_we), .ovf(ovf_q), .flags(flag_q), .irq(irq_o)
);

// File: tb/sim_ccu_array.sv
`timescale 1ns/1ps
module sim_ccu_array;
  localparam int N = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_i = 0, t0_ovf_i = 0, ext_cnt_i = 0;
  logic [N-1:0] cc_pin_i = '0;
  logic [N-1:0] cc_pin_o;
  logic reg_we = 0;
  logic [4:0] reg_addr = 5'd2;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_o;

  always #10 clk = ~clk;

  ccu_array u0 (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .t0_ovf_i(t0_ovf_i),
    .ext_cnt_i(ext_cnt_i), .cc_pin_i(cc_pin_i), .cc_pin_o(cc_pin_o),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  string cur = "R12";
  logic [4:0] view = 5'd2;

  // behavioural reference state
  int p12 = 0, p4 = 0;
  bit e1, e2, e3;
  logic [N-1:0] q1, q2, q3;
  logic [15:0] m_cnt;
  bit m_run, m_ovf, m_ie, m_idl, m_step;
  logic [1:0] m_src;
  logic [N-1:0] m_flg, m_pin;
  logic [6:0] m_mode [N];
  logic [15:0] m_cc [N];

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(int a);
    if (a == 0) return {m_ovf, m_run, 1'b0, m_flg};
    if (a == 1) return {m_idl, 4'b0, m_src, m_ie};
    if (a == 2) return m_cnt[7:0];
    if (a == 3) return m_cnt[15:8];
    for (int i = 0; i < N; i++) begin
      if (a == 4 + i) return {1'b0, m_mode[i]};
      if (a == 9 + 2*i) return m_cc[i][7:0];
      if (a == 10 + 2*i) return m_cc[i][15:8];
    end
    return 8'h00;
  endfunction

  function automatic bit m_irq();
    bit r = m_ovf && m_ie;
    for (int i = 0; i < N; i++) if (m_flg[i] && m_mode[i][0]) r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      p12 = 0; p4 = 0; e1 = 0; e2 = 0; e3 = 0; q1 = 0; q2 = 0; q3 = 0;
      m_cnt = 0; m_run = 0; m_ovf = 0; m_ie = 0; m_idl = 0; m_step = 0;
      m_src = 0; m_flg = 0; m_pin = 0;
      for (int i = 0; i < N; i++) begin m_mode[i] = 0; m_cc[i] = 0; end
    end else begin
      bit tk, cw, inc, ctw;
      logic [N-1:0] hits;
      int a;
      a = reg_addr;
      case (m_src)
        2'b00: tk = (p12 == 11);
        2'b01: tk = (p4 == 3);
        2'b10: tk = t0_ovf_i;
        default: tk = e2 && !e3;
      endcase
      cw  = reg_we && (a == 2 || a == 3);
      ctw = reg_we && a == 0;
      inc = m_run && !(m_idl && idle_i) && tk && !cw;
      hits = 0;
      for (int i = 0; i < N; i++) begin
        bit cap, mt;
        cap = (m_mode[i][5] && q2[i] && !q3[i]) || (m_mode[i][4] && !q2[i] && q3[i]);
        mt  = m_step && m_mode[i][6] && m_mode[i][3] && (m_cnt == m_cc[i]);
        hits[i] = cap || mt;
        if (mt && m_mode[i][2]) m_pin[i] = !m_pin[i];
        if (cap) m_cc[i] = m_cnt;
        else if (reg_we && a == 9 + 2*i) m_cc[i][7:0] = reg_wdata;
        else if (reg_we && a == 10 + 2*i) m_cc[i][15:8] = reg_wdata;
        if (reg_we && a == 4 + i) m_mode[i] = reg_wdata[6:0];
      end
      m_flg = (ctw ? reg_wdata[N-1:0] : m_flg) | hits;
      m_ovf = (ctw ? reg_wdata[7] : m_ovf) | (inc && m_cnt == 16'hFFFF);
      if (ctw) m_run = reg_wdata[6];
      if (reg_we && a == 1) begin
        m_ie = reg_wdata[0]; m_src = reg_wdata[2:1]; m_idl = reg_wdata[7];
      end
      if (reg_we && a == 2) m_cnt[7:0] = reg_wdata;
      else if (reg_we && a == 3) m_cnt[15:8] = reg_wdata;
      else if (inc) m_cnt = m_cnt + 16'd1;
      m_step = inc;
      p12 = (p12 == 11) ? 0 : p12 + 1;
      p4  = (p4 == 3) ? 0 : p4 + 1;
      e3 = e2; e2 = e1; e1 = ext_cnt_i;
      q3 = q2; q2 = q1; q1 = cc_pin_i;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(reg_rdata == m_read(reg_addr), "rdata", reg_rdata, m_read(reg_addr));
      check(irq_o == m_irq(), "irq_o R11", irq_o, m_irq());
      check(cc_pin_o == m_pin, "cc_pin_o", cc_pin_o, m_pin);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0; reg_addr = view;
  endtask

  task automatic look(int a);
    @(posedge clk); #2;
    view = 5'(a); reg_addr = view;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (%s) act=running exp=done", cur);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    // R12 reset values and outputs
    check(irq_o == 0 && cc_pin_o == 0, "reset outputs R12", {irq_o, cc_pin_o}, 0);
    rst_n = 1;
    for (int a = 0; a < 24; a++) look(a);
    look(2);
    // R1 divide-by-4 then divide-by-12
    cur = "R1";
    wr(1, 8'h02); wr(0, 8'h40); cyc(40);
    look(3); look(2);
    wr(1, 8'h00); cyc(60);
    wr(1, 8'h04);
    for (int k = 0; k < 6; k++) begin
      t0_ovf_i = 1; cyc(1); t0_ovf_i = 0; cyc(k + 1);
    end
    // R2 external count source, held levels count once
    cur = "R2";
    wr(1, 8'h06);
    for (int k = 0; k < 10; k++) begin
      ext_cnt_i = 1; cyc(4 + k); ext_cnt_i = 0; cyc(4);
    end
    // R3 run bit off holds the counter
    cur = "R3";
    wr(1, 8'h02); wr(0, 8'h00); cyc(20); wr(0, 8'h40); cyc(8);
    // R5 idle gating on, then off
    cur = "R5";
    wr(1, 8'h82); idle_i = 1; cyc(20); idle_i = 0; cyc(8);
    wr(1, 8'h02); idle_i = 1; cyc(12); idle_i = 0;
    // R4 wrap and overflow interrupt
    cur = "R4";
    wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h03); look(0); cyc(80);
    cur = "R11";
    wr(0, 8'h40); cyc(4);
    // R6 / R7 capture edges
    cur = "R6";
    wr(4, 8'h21); wr(5, 8'h11); wr(6, 8'h30);
    cur = "R7";
    look(9);
    cc_pin_i = 5'b00111; cyc(10); look(13);
    cc_pin_i = 5'b00000; cyc(10); look(11); look(0);
    // R12 counter write beside increments
    cur = "R12";
    wr(2, 8'h10); cyc(6); wr(0, 8'h40);
    // R8 software timer match, counter dwells on match value
    cur = "R8";
    wr(15, 8'(m_cnt + 16'd12)); wr(16, 8'((m_cnt + 16'd12) >> 8));
    wr(7, 8'h49); cyc(90);
    // R9 toggle on match
    cur = "R9";
    wr(17, 8'(m_cnt + 16'd6)); wr(18, 8'((m_cnt + 16'd6) >> 8));
    wr(8, 8'h4C); cyc(60);
    wr(17, 8'(m_cnt + 16'd5)); cyc(60);
    // R13 PWM bit has no effect
    cur = "R13";
    wr(8, 8'h4E); wr(17, 8'(m_cnt + 16'd5)); wr(18, 8'((m_cnt + 16'd5) >> 8));
    look(8); cyc(50); look(0);
    // R10 flag set colliding with a clearing write
    cur = "R10";
    for (int off = 0; off < 8; off++) begin
      cc_pin_i[0] = ~cc_pin_i[0]; cc_pin_i[2] = ~cc_pin_i[2];
      cyc(off);
      wr(0, 8'h40); cyc(3);
    end
    wr(0, 8'hDF); cyc(3); wr(0, 8'h40); cyc(3);
    cur = "R11";
    wr(1, 8'h00); wr(0, 8'h81); cyc(4); wr(4, 8'h20); cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule